// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes one trap request per cycle and works out where the hart goes next. A request carries a cause word, the PC of the trapping instruction and a trap value. The block looks at the current privilege, the two delegation masks, the two trap vector bases and the debug control bits. It then picks one of four routes. A hart already in debug mode is redirected inside debug space. A breakpoint may be promoted to debug-mode entry. A trap may be handed to the supervisor handler, or it goes to the machine handler.

The chosen route is committed as a single registered bundle. One cycle after the request, the block presents all of the following at once:

- the redirect PC;
- the new privilege;
- one write strobe, naming which register group the surrounding state must update (supervisor, machine or debug);
- the values for that group's cause, EPC, trap value, previous-enable and previous-privilege fields.

Software writes to the control registers and instruction execution are handled elsewhere.

The cause word uses its top bit as the interrupt flag. The remaining bits form the cause index. Privilege is encoded as U=0, S=1 and M=3.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `redir_valid`, `s_upd`, `m_upd` and `dbg_upd` are all low.
- R2: A request with `trap_valid` high produces `redir_valid` high on the next clock edge, for one cycle per request. Back-to-back requests give back-to-back results. With no request, `redir_valid` stays low.
- R3: When `dbg_active` is high, a cause equal to 3 (breakpoint, interrupt flag clear) redirects to `DBG_ENTRY_PC`. Any other cause redirects to `DBG_EXC_PC`. No update strobe is raised, and `priv_out` equals the current privilege.
- R4: When not in debug, a breakpoint whose privilege-matched enable is set raises `dbg_upd`. The enables are `ebrk_en_m`, `ebrk_en_s` and `ebrk_en_u`. In this case `priv_out` is M, `redir_pc` is `DBG_ENTRY_PC`, `dbg_cause_out` is 1, `prev_priv_out` is the current privilege and `epc_out` is the request EPC. A breakpoint whose matching enable is clear takes the normal route.
- R5: For an interrupt (cause bit XLEN-1 set), delegation is looked up in `ideleg`. For an exception it is looked up in `edeleg`. In both cases the index is the cause with its top bit cleared.
- R6: A trap goes to the supervisor only when the current privilege is U or S, the index is below XLEN, and the selected delegation bit is set. Every other non-debug trap, including any trap taken in M, goes to the machine.
- R7: On supervisor entry, the unit raises `s_upd`. `redir_pc` is `svec`, `priv_out` is S and `prev_ie_out` is `cur_sie`. `prev_priv_out` is 1 for an S origin and 0 for a U origin, with bit 1 always zero. `cause_out`, `epc_out` and `tval_out` repeat the request.
- R8: On machine entry, the unit raises `m_upd`. `priv_out` is M and `prev_ie_out` is `cur_mie`. `prev_priv_out` is the full 2-bit current privilege. Cause, EPC and value repeat the request.
- R9: The machine redirect PC is `mvec` with bit 0 cleared. If the trap is an interrupt and `mvec` bit 0 is set, four times the cause index is added.
- R10: At most one of `s_upd`, `m_upd` and `dbg_upd` is high in any cycle, and none is high without `redir_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_cause | input | XLEN | Cause word, top bit is the interrupt flag |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| cur_mie | input | 1 | Current machine interrupt enable |
| dbg_active | input | 1 | Hart is already in debug mode |
| ebrk_en_m | input | 1 | Breakpoint-to-debug enable for M |
| ebrk_en_s | input | 1 | Breakpoint-to-debug enable for S |
| ebrk_en_u | input | 1 | Breakpoint-to-debug enable for U |
| edeleg | input | XLEN | Exception delegation mask |
| ideleg | input | XLEN | Interrupt delegation mask |
| svec | input | XLEN | Supervisor trap vector base |
| mvec | input | XLEN | Machine trap vector, bit 0 selects vectored interrupts |
| redir_valid | output | 1 | Registered result valid |
| redir_pc | output | XLEN | New PC |
| priv_out | output | 2 | New privilege |
| s_upd | output | 1 | Write supervisor cause/EPC/value/status fields |
| m_upd | output | 1 | Write machine cause/EPC/value/status fields |
| dbg_upd | output | 1 | Write debug cause, debug privilege and debug PC |
| cause_out | output | XLEN | Cause to store |
| epc_out | output | XLEN | EPC (or debug PC) to store |
| tval_out | output | XLEN | Trap value to store |
| prev_ie_out | output | 1 | Previous-enable value to store |
| prev_priv_out | output | 2 | Previous-privilege value to store |
| dbg_cause_out | output | 3 | Debug entry cause code |

## Verification
Breakpoints are driven from each privilege with the enables set one at a time. This shows whether the enable that matches the current privilege is the one that decides promotion. The same cause index is sent once as an interrupt and once as an exception, with `ideleg` and `edeleg` set to opposite values. This separates the two delegation masks. Delegated causes are also raised from U, S and M, and an index above XLEN is raised with every mask bit set. These show that the privilege and range gates override the mask. Finally, interrupts and exceptions are issued with the vectored mode bit on and off, and two requests are placed in consecutive cycles, to check the vector offset and the one-cycle pipeline.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ROUTE_DBG_STAY,
        ROUTE_DBG_ENTER,
        ROUTE_SUP,
        ROUTE_MACH
    } route_e;

    localparam int unsigned BRK_CAUSE      = 3;
    localparam logic [2:0]  DBG_CAUSE_SWBRK = 3'd1;

    typedef struct packed {
        logic       s_upd;
        logic       m_upd;
        logic       dbg_upd;
        priv_e      priv;
        logic       prev_ie;
        logic [1:0] prev_priv;
    } entry_ctl_t;

    function automatic logic brk_enabled(priv_e p, logic en_m, logic en_s, logic en_u);
        case (p)
            PRIV_M:  return en_m;
            PRIV_S:  return en_s;
            PRIV_U:  return en_u;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  priv_e           priv,
    input  logic            dbg_active,
    input  logic            en_m,
    input  logic            en_s,
    input  logic            en_u,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    output route_e          route,
    output logic            is_intr,
    output logic [XLEN-2:0] idx
);
    localparam int LW = $clog2(XLEN);

    logic            is_brk;
    logic            in_range;
    logic [XLEN-1:0] mask;
    logic            deleg_bit;
    logic            low_priv;

    always_comb begin
        is_intr   = cause[XLEN-1];
        idx       = cause[XLEN-2:0];
        is_brk    = (cause == XLEN'(BRK_CAUSE));
        in_range  = ((idx >> LW) == '0);
        mask      = is_intr ? ideleg : edeleg;
        deleg_bit = in_range && mask[idx[LW-1:0]];
        low_priv  = (priv == PRIV_U) || (priv == PRIV_S);

        if (dbg_active)
            route = ROUTE_DBG_STAY;
        else if (is_brk && brk_enabled(priv, en_m, en_s, en_u))
            route = ROUTE_DBG_ENTER;
        else if (low_priv && deleg_bit)
            route = ROUTE_SUP;
        else
            route = ROUTE_MACH;
    end

endmodule

// File: rtl/trap_mvec.sv
module trap_mvec #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] mvec,
    input  logic            is_intr,
    input  logic [XLEN-2:0] idx,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    always_comb begin
        base = {mvec[XLEN-1:1], 1'b0};
        offs = {idx[XLEN-3:0], 2'b00};
        pc   = (is_intr && mvec[0]) ? base + offs : base;
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int               XLEN         = 32,
    parameter logic [XLEN-1:0]  DBG_ENTRY_PC = 32'h0000_0800,
    parameter logic [XLEN-1:0]  DBG_EXC_PC   = 32'h0000_0808
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic [XLEN-1:0] trap_tval,
    input  logic [1:0]      cur_priv,
    input  logic            cur_sie,
    input  logic            cur_mie,
    input  logic            dbg_active,
    input  logic            ebrk_en_m,
    input  logic            ebrk_en_s,
    input  logic            ebrk_en_u,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    input  logic [XLEN-1:0] svec,
    input  logic [XLEN-1:0] mvec,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic [1:0]      priv_out,
    output logic            s_upd,
    output logic            m_upd,
    output logic            dbg_upd,
    output logic [XLEN-1:0] cause_out,
    output logic [XLEN-1:0] epc_out,
    output logic [XLEN-1:0] tval_out,
    output logic            prev_ie_out,
    output logic [1:0]      prev_priv_out,
    output logic [2:0]      dbg_cause_out
);
    priv_e           priv_now;
    route_e          route;
    logic            is_intr;
    logic [XLEN-2:0] idx;
    logic [XLEN-1:0] m_pc;
    logic [XLEN-1:0] nxt_pc;
    entry_ctl_t      nxt_ctl;
    entry_ctl_t      ctl_q;

    assign priv_now = priv_e'(cur_priv);

    trap_route #(.XLEN(XLEN)) u_route (
        .cause      (trap_cause),
        .priv       (priv_now),
        .dbg_active (dbg_active),
        .en_m       (ebrk_en_m),
        .en_s       (ebrk_en_s),
        .en_u       (ebrk_en_u),
        .edeleg     (edeleg),
        .ideleg     (ideleg),
        .route      (route),
        .is_intr    (is_intr),
        .idx        (idx)
    );

    trap_mvec #(.XLEN(XLEN)) u_mvec (
        .mvec    (mvec),
        .is_intr (is_intr),
        .idx     (idx),
        .pc      (m_pc)
    );

    always_comb begin
        nxt_ctl = '{s_upd: 1'b0, m_upd: 1'b0, dbg_upd: 1'b0, priv: priv_now,
                    prev_ie: 1'b0, prev_priv: cur_priv};
        nxt_pc  = m_pc;
        case (route)
            ROUTE_DBG_STAY: begin
                nxt_pc = (trap_cause == XLEN'(BRK_CAUSE)) ? DBG_ENTRY_PC : DBG_EXC_PC;
            end
            ROUTE_DBG_ENTER: begin
                nxt_ctl.dbg_upd = 1'b1;
                nxt_ctl.priv    = PRIV_M;
                nxt_pc          = DBG_ENTRY_PC;
            end
            ROUTE_SUP: begin
                nxt_ctl.s_upd     = 1'b1;
                nxt_ctl.priv      = PRIV_S;
                nxt_ctl.prev_ie   = cur_sie;
                nxt_ctl.prev_priv = {1'b0, cur_priv[0]};
                nxt_pc            = svec;
            end
            default: begin
                nxt_ctl.m_upd   = 1'b1;
                nxt_ctl.priv    = PRIV_M;
                nxt_ctl.prev_ie = cur_mie;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid   <= 1'b0;
            ctl_q         <= '{s_upd: 1'b0, m_upd: 1'b0, dbg_upd: 1'b0, priv: PRIV_M,
                               prev_ie: 1'b0, prev_priv: 2'b00};
            redir_pc      <= '0;
            cause_out     <= '0;
            epc_out       <= '0;
            tval_out      <= '0;
            dbg_cause_out <= '0;
        end else begin
            redir_valid <= trap_valid;
            if (trap_valid) begin
                ctl_q         <= nxt_ctl;
                redir_pc      <= nxt_pc;
                cause_out     <= trap_cause;
                epc_out       <= trap_epc;
                tval_out      <= trap_tval;
                dbg_cause_out <= DBG_CAUSE_SWBRK;
            end else begin
                ctl_q.s_upd   <= 1'b0;
                ctl_q.m_upd   <= 1'b0;
                ctl_q.dbg_upd <= 1'b0;
            end
        end
    end

    assign s_upd         = ctl_q.s_upd;
    assign m_upd         = ctl_q.m_upd;
    assign dbg_upd       = ctl_q.dbg_upd;
    assign priv_out      = ctl_q.priv;
    assign prev_ie_out   = ctl_q.prev_ie;
    assign prev_priv_out = ctl_q.prev_priv;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY_PC = 32'h0000_0800
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic [1:0]      cur_priv,
    input logic            dbg_active,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic [1:0]      priv_out,
    input logic            s_upd,
    input logic            m_upd,
    input logic            dbg_upd,
    input logic [1:0]      prev_priv_out
);
    // R10
    one_group_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s_upd, m_upd, dbg_upd}) && ((s_upd || m_upd || dbg_upd) -> redir_valid));

    // R2
    req_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> redir_valid);

    // R2
    no_req_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> !redir_valid);

    // R7
    sup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        s_upd |-> (priv_out == 2'b01) && (prev_priv_out[1] == 1'b0));

    // R8
    mach_entry_chk: assert property (@(posedge clk) disable iff (rst)
        m_upd |-> (priv_out == 2'b11));

    // R4
    dbg_enter_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_upd |-> (priv_out == 2'b11) && (redir_pc == DBG_ENTRY_PC));

    // R6
    no_deleg_from_m_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == 2'b11 && !dbg_active) |=> !s_upd);

    // R3
    dbg_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && dbg_active) |=> !(s_upd || m_upd || dbg_upd) && (priv_out == $past(cur_priv)));

endmodule

bind trap_entry_unit trap_entry_chk #(
    .XLEN         (XLEN),
    .DBG_ENTRY_PC (DBG_ENTRY_PC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .trap_valid    (trap_valid),
    .cur_priv      (cur_priv),
    .dbg_active    (dbg_active),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .priv_out      (priv_out),
    .s_upd         (s_upd),
    .m_upd         (m_upd),
    .dbg_upd       (dbg_upd),
    .prev_priv_out (prev_priv_out)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
    localparam int          XLEN = 32;
    localparam logic [31:0] DENT = 32'h0000_0800;
    localparam logic [31:0] DEXC = 32'h0000_0808;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        trap_valid = 1'b0;
    logic [31:0] trap_cause = '0, trap_epc = '0, trap_tval = '0;
    logic [1:0]  cur_priv = 2'b11;
    logic        cur_sie = 1'b0, cur_mie = 1'b0, dbg_active = 1'b0;
    logic        ebrk_en_m = 1'b0, ebrk_en_s = 1'b0, ebrk_en_u = 1'b0;
    logic [31:0] edeleg = '0, ideleg = '0, svec = '0, mvec = '0;
    logic        redir_valid, s_upd, m_upd, dbg_upd, prev_ie_out;
    logic [31:0] redir_pc, cause_out, epc_out, tval_out;
    logic [1:0]  priv_out, prev_priv_out;
    logic [2:0]  dbg_cause_out;

    trap_entry_unit #(.XLEN(XLEN), .DBG_ENTRY_PC(DENT), .DBG_EXC_PC(DEXC)) u0 (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_epc(trap_epc), .trap_tval(trap_tval), .cur_priv(cur_priv),
        .cur_sie(cur_sie), .cur_mie(cur_mie), .dbg_active(dbg_active),
        .ebrk_en_m(ebrk_en_m), .ebrk_en_s(ebrk_en_s), .ebrk_en_u(ebrk_en_u),
        .edeleg(edeleg), .ideleg(ideleg), .svec(svec), .mvec(mvec),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .priv_out(priv_out),
        .s_upd(s_upd), .m_upd(m_upd), .dbg_upd(dbg_upd), .cause_out(cause_out),
        .epc_out(epc_out), .tval_out(tval_out), .prev_ie_out(prev_ie_out),
        .prev_priv_out(prev_priv_out), .dbg_cause_out(dbg_cause_out)
    );

    typedef struct {
        int          cyc;
        string       req;
        logic [31:0] pc;
        logic [1:0]  priv;
        logic        s, m, d;
        logic [31:0] cause, epc, tval;
        logic        pie;
        logic [1:0]  ppriv;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0, cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected result written from the requirement list
    task automatic drive(string req, logic [31:0] cause, logic [1:0] pv,
                         logic [31:0] epc, logic [31:0] tval);
        exp_t e;
        logic intr, brk, en, sdel;
        logic [30:0] ix;
        logic [31:0] dm;
        intr = cause[31];
        ix   = cause[30:0];
        brk  = (cause == 32'd3);
        en   = (pv == 2'b11) ? ebrk_en_m : (pv == 2'b01) ? ebrk_en_s :
               (pv == 2'b00) ? ebrk_en_u : 1'b0;
        dm   = intr ? ideleg : edeleg;
        sdel = (pv == 2'b00 || pv == 2'b01) && (ix < 31'd32) && dm[ix[4:0]];
        e = '{cyc: cyc, req: req, pc: '0, priv: pv, s: 0, m: 0, d: 0,
              cause: cause, epc: epc, tval: tval, pie: 0, ppriv: pv};
        if (dbg_active) begin
            e.pc = brk ? DENT : DEXC;
        end else if (brk && en) begin
            e.d = 1; e.priv = 2'b11; e.pc = DENT;
        end else if (sdel) begin
            e.s = 1; e.priv = 2'b01; e.pc = svec; e.pie = cur_sie;
            e.ppriv = (pv == 2'b01) ? 2'b01 : 2'b00;
        end else begin
            e.m = 1; e.priv = 2'b11; e.pie = cur_mie;
            e.pc = (mvec & ~32'd1) + ((intr && mvec[0]) ? 32'(ix) * 4 : 32'd0);
        end
        q.push_back(e);
        trap_cause = cause; cur_priv = pv; trap_epc = epc; trap_tval = tval;
        trap_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        trap_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: scoreboard comparison
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (q.size() > 0 && cyc > q[0].cyc) begin
                exp_t e;
                e = q.pop_front();
                chk("R2", "redir_valid", 32'(redir_valid), 32'd1);
                chk(e.req, "redir_pc", redir_pc, e.pc);
                chk(e.req, "priv_out", 32'(priv_out), 32'(e.priv));
                chk("R10", "upd flags", {29'd0, s_upd, m_upd, dbg_upd}, {29'd0, e.s, e.m, e.d});
                if (e.s || e.m || e.d) begin
                    chk(e.req, "epc_out", epc_out, e.epc);
                    chk(e.req, "prev_priv_out", 32'(prev_priv_out), 32'(e.ppriv));
                end
                if (e.s || e.m) begin
                    chk(e.req, "cause_out", cause_out, e.cause);
                    chk(e.req, "tval_out", tval_out, e.tval);
                    chk(e.req, "prev_ie_out", 32'(prev_ie_out), 32'(e.pie));
                end
                if (e.d) chk("R4", "dbg_cause_out", 32'(dbg_cause_out), 32'd1);
            end else if (redir_valid) begin
                chk("R2", "unexpected redir_valid", 32'd1, 32'd0);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        svec = 32'h0000_4000;
        mvec = 32'h0000_8000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "flags in reset", {28'd0, redir_valid, s_upd, m_upd, dbg_upd}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "flags after reset", {28'd0, redir_valid, s_upd, m_upd, dbg_upd}, 32'd0);

        // R3: already in debug
        dbg_active = 1'b1; ebrk_en_u = 1'b1; edeleg = 32'hFFFF_FFFF;
        drive("R3", 32'd3, 2'b00, 32'h100, 32'h0);
        drive("R3", 32'd5, 2'b01, 32'h104, 32'h55);
        idle(2);
        dbg_active = 1'b0; edeleg = '0;

        // R4: breakpoint promotion per privilege
        drive("R4", 32'd3, 2'b00, 32'h200, 32'h1);
        ebrk_en_u = 1'b0; ebrk_en_m = 1'b1; edeleg = 32'h0000_0008;
        drive("R4", 32'd3, 2'b01, 32'h204, 32'h2);   // S enable clear -> supervisor
        drive("R4", 32'd3, 2'b11, 32'h208, 32'h3);   // M enable set -> debug
        idle(2);
        ebrk_en_m = 1'b0;

        // R7: supervisor entry from U and S
        edeleg = 32'h0000_0104; cur_sie = 1'b1;
        drive("R7", 32'd8, 2'b00, 32'h300, 32'hAA);
        cur_sie = 1'b0;
        drive("R7", 32'd2, 2'b01, 32'h304, 32'hBB);
        // R6: same delegated cause from M goes to machine
        cur_mie = 1'b1;
        drive("R6", 32'd2, 2'b11, 32'h308, 32'hCC);
        // R8: machine entry from S, undelegated cause
        drive("R8", 32'd6, 2'b01, 32'h30C, 32'hDD);
        idle(2);

        // R5: interrupt uses ideleg, exception uses edeleg
        ideleg = 32'h0000_0020; edeleg = 32'h0000_0200; mvec = 32'h0000_8001;
        drive("R5", 32'h8000_0005, 2'b01, 32'h400, 32'h0);
        drive("R5", 32'h8000_0009, 2'b01, 32'h404, 32'h0);  // R9 vectored +36
        drive("R5", 32'd5, 2'b00, 32'h408, 32'h7);
        // R9: exception with vectored mode ignores offset
        drive("R9", 32'd9, 2'b11, 32'h40C, 32'h8);
        mvec = 32'h0000_8000;
        drive("R9", 32'h8000_0007, 2'b11, 32'h410, 32'h0);
        // R6: index above XLEN never delegated
        edeleg = 32'hFFFF_FFFF; ideleg = 32'hFFFF_FFFF;
        drive("R6", 32'd40, 2'b00, 32'h414, 32'h9);
        drive("R6", 32'h8000_0021, 2'b01, 32'h418, 32'h0);
        idle(3);
        // R2: idle produces nothing
        chk("R2", "idle redir_valid", 32'(redir_valid), 32'd0);

        done = 1'b1;
        chk("R2", "scoreboard drained", 32'(q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule